// File: doc/BRIEF.md
# PLL Control Register Guard

This block is a register slave that sits between a simple memory-mapped bus and a phase-locked loop. It keeps two copies of the PLL controls. One is a pending copy that software writes freely. The other is an active copy that drives the PLL: the run bit, the connect bit, the multiplier and the pre-divider. Software writes only ever reach the pending copy. Software moves pending values into the active copy by writing two fixed key bytes to a feed register in order. No other access to the guarded address range may fall between the two key writes.

At each commit, legality rules decide what the PLL actually receives. A new configuration is taken only while the PLL is stopped. The connect bit is taken only if the PLL is already running, stays enabled, and reports lock. The active copy and the live lock input can be read back through a status register. Each pending value reads back at its own address.

Top module: `pll_feed_guard`

## Requirements
- R1: After reset the active run and connect bits are 0, and the active multiplier and pre-divider hold the parameter defaults. The pending copy holds the same values: run and connect 0, configuration at the defaults.
- R2: Writes to the control address (0x00; bit 0 run, bit 1 connect) and the configuration address (0x04; multiplier in bits 7:0, pre-divider in bits 20:16) change only the pending copy. That copy reads back at the same addresses, and the active copy does not change without a feed.
- R3: A write of 0xAA to the feed address (0x08, low byte), followed later by a write of 0x55, commits the pending copy. The active outputs change at the second rising clock edge after the 0x55 write is presented, that is, one cycle after that write is sampled.
- R4: A feed write whose first value is not 0xAA leaves the sequence idle, so a following 0x55 commits nothing.
- R5: After 0xAA, a feed write of any value other than 0x55 ends the sequence without a commit.
- R6: After 0xAA, any read or write to an address inside the guarded range (0x00 to 0x1F) other than the feed address ends the sequence without a commit. Accesses outside the range do not.
- R7: A commit updates the multiplier and pre-divider only if the active run bit is 0 at that moment. Otherwise they keep their value.
- R8: A commit sets the active connect bit only if the active run bit is already 1, the pending run bit is 1, and the lock input is high at the commit cycle. Otherwise the connect bit becomes 0.
- R9: A commit copies the pending run bit into the active run bit. Clearing the run bit also clears the connect bit.
- R10: When read enable is low, the read data is 0, and it is 0 for an address that maps to no register. The status address (0x0C) returns the active multiplier in bits 7:0, the pre-divider in bits 20:16, run in bit 24, connect in bit 25 and the live lock input in bit 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Bus address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational from address |
| lock_i | input | 1 | Lock indication from the PLL |
| pll_run_o | output | 1 | Active run (enable) bit |
| pll_conn_o | output | 1 | Active connect bit |
| pll_mul_o | output | MUL_W | Active multiplier |
| pll_pdiv_o | output | PDIV_W | Active pre-divider |

## Verification
The unlock path is tried with a correct key pair and with each way of spoiling it. These are a wrong first key, a wrong second key, a foreign read and a foreign write inside the guarded range between the keys, and traffic outside the range between the keys. Only the range test separates a correct abort from one that is too broad. Commits are then repeated with the PLL stopped, running, running without lock and running with lock. This shows that configuration freezing and connect gating depend on the active state before the commit and not on the pending values. A directed test samples the status on both sides of the commit edge to pin down the one-cycle latency.

// File: rtl/pll_guard_pkg.sv
`timescale 1ns/1ps
package pll_guard_pkg;
  typedef enum logic {FEED_IDLE, FEED_ARMED} feed_state_e;

  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_CONN_BIT = 1;
  localparam int CFG_PDIV_LSB  = 16;
  localparam int STAT_RUN_BIT  = 24;
  localparam int STAT_CONN_BIT = 25;
  localparam int STAT_LOCK_BIT = 26;
endpackage

// File: rtl/pll_feed_seq.sv
`timescale 1ns/1ps
module pll_feed_seq import pll_guard_pkg::*; #(
  parameter int              AW        = 8,
  parameter logic [AW-1:0]   FEED_ADDR = 'h08,
  parameter logic [AW-1:0]   WIN_LO    = 'h00,
  parameter logic [AW-1:0]   WIN_HI    = 'h1F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [7:0]    key_i,
  output logic          commit_o
);
  localparam logic [AW-1:0] WIN_SPAN = WIN_HI - WIN_LO;

  feed_state_e   state_q, state_d;
  logic          commit_d;
  logic [AW-1:0] win_off;
  logic          in_win, hit_feed, foreign;

  assign win_off  = addr_i - WIN_LO;
  assign in_win   = (win_off <= WIN_SPAN);
  assign hit_feed = (addr_i == FEED_ADDR);
  assign foreign  = (wr_en_i || rd_en_i) && in_win && !hit_feed;

  always_comb begin
    state_d  = state_q;
    commit_d = 1'b0;
    unique case (state_q)
      FEED_IDLE:
        if (wr_en_i && hit_feed && key_i == FEED_KEY1) state_d = FEED_ARMED;
      FEED_ARMED:
        if (wr_en_i && hit_feed) begin
          state_d  = FEED_IDLE;
          commit_d = (key_i == FEED_KEY2);
        end else if (foreign) begin
          state_d = FEED_IDLE;
        end
      default: state_d = FEED_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FEED_IDLE;
      commit_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      commit_o <= commit_d;
    end
  end

  // commit only one cycle after a second key seen while armed
  p_commit_key2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_en_i && hit_feed && key_i == FEED_KEY2));

  p_bad_key1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FEED_IDLE && wr_en_i && hit_feed && key_i != FEED_KEY1)
      |=> (state_q == FEED_IDLE && !commit_o));

  p_bad_key2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FEED_ARMED && wr_en_i && hit_feed && key_i != FEED_KEY2)
      |=> !commit_o);

  p_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FEED_ARMED && foreign) |=> (state_q == FEED_IDLE && !commit_o));
endmodule

// File: rtl/pll_shadow_regs.sv
`timescale 1ns/1ps
module pll_shadow_regs #(
  parameter int                MUL_W    = 8,
  parameter int                PDIV_W   = 5,
  parameter logic [MUL_W-1:0]  MUL_DEF  = 'h10,
  parameter logic [PDIV_W-1:0] PDIV_DEF = 'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_cfg_i,
  input  logic              run_i,
  input  logic              conn_i,
  input  logic [MUL_W-1:0]  mul_i,
  input  logic [PDIV_W-1:0] pdiv_i,
  output logic              pend_run_o,
  output logic              pend_conn_o,
  output logic [MUL_W-1:0]  pend_mul_o,
  output logic [PDIV_W-1:0] pend_pdiv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_run_o  <= 1'b0;
      pend_conn_o <= 1'b0;
    end else if (wr_ctrl_i) begin
      pend_run_o  <= run_i;
      pend_conn_o <= conn_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_mul_o  <= MUL_DEF;
      pend_pdiv_o <= PDIV_DEF;
    end else if (wr_cfg_i) begin
      pend_mul_o  <= mul_i;
      pend_pdiv_o <= pdiv_i;
    end
  end

  p_pend_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg_i |=> ($stable(pend_mul_o) && $stable(pend_pdiv_o)));
endmodule

// File: rtl/pll_commit_regs.sv
`timescale 1ns/1ps
module pll_commit_regs #(
  parameter int                MUL_W    = 8,
  parameter int                PDIV_W   = 5,
  parameter logic [MUL_W-1:0]  MUL_DEF  = 'h10,
  parameter logic [PDIV_W-1:0] PDIV_DEF = 'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              lock_i,
  input  logic              pend_run_i,
  input  logic              pend_conn_i,
  input  logic [MUL_W-1:0]  pend_mul_i,
  input  logic [PDIV_W-1:0] pend_pdiv_i,
  output logic              run_o,
  output logic              conn_o,
  output logic [MUL_W-1:0]  mul_o,
  output logic [PDIV_W-1:0] pdiv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      conn_o <= 1'b0;
      mul_o  <= MUL_DEF;
      pdiv_o <= PDIV_DEF;
    end else if (commit_i) begin
      run_o  <= pend_run_i;
      // connect needs a running, locked PLL that stays enabled
      conn_o <= pend_conn_i && pend_run_i && run_o && lock_i;
      if (!run_o) begin
        mul_o  <= pend_mul_i;
        pdiv_o <= pend_pdiv_i;
      end
    end
  end

  p_hold_no_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(run_o) && $stable(conn_o) && $stable(mul_o) && $stable(pdiv_o)));

  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> ($stable(mul_o) && $stable(pdiv_o)));

  p_conn_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conn_o) |-> ($past(run_o) && $past(lock_i)));

  p_conn_needs_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conn_o |-> run_o);
endmodule

// File: rtl/pll_feed_guard.sv
`timescale 1ns/1ps
module pll_feed_guard import pll_guard_pkg::*; #(
  parameter int                AW        = 8,
  parameter int                DW        = 32,
  parameter int                MUL_W     = 8,
  parameter int                PDIV_W    = 5,
  parameter logic [AW-1:0]     CTRL_ADDR = 'h00,
  parameter logic [AW-1:0]     CFG_ADDR  = 'h04,
  parameter logic [AW-1:0]     FEED_ADDR = 'h08,
  parameter logic [AW-1:0]     STAT_ADDR = 'h0C,
  parameter logic [AW-1:0]     WIN_LO    = 'h00,
  parameter logic [AW-1:0]     WIN_HI    = 'h1F,
  parameter logic [MUL_W-1:0]  MUL_DEF   = 'h10,
  parameter logic [PDIV_W-1:0] PDIV_DEF  = 'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              lock_i,
  output logic              pll_run_o,
  output logic              pll_conn_o,
  output logic [MUL_W-1:0]  pll_mul_o,
  output logic [PDIV_W-1:0] pll_pdiv_o
);
  logic              commit;
  logic              pend_run, pend_conn;
  logic [MUL_W-1:0]  pend_mul;
  logic [PDIV_W-1:0] pend_pdiv;
  logic              wr_ctrl, wr_cfg;
  logic              unused_wdata;

  assign wr_ctrl      = wr_en_i && (addr_i == CTRL_ADDR);
  assign wr_cfg       = wr_en_i && (addr_i == CFG_ADDR);
  assign unused_wdata = ^wdata_i;

  pll_feed_seq #(
    .AW(AW), .FEED_ADDR(FEED_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_feed (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .key_i    (wdata_i[7:0]),
    .commit_o (commit)
  );

  pll_shadow_regs #(
    .MUL_W(MUL_W), .PDIV_W(PDIV_W), .MUL_DEF(MUL_DEF), .PDIV_DEF(PDIV_DEF)
  ) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctrl_i   (wr_ctrl),
    .wr_cfg_i    (wr_cfg),
    .run_i       (wdata_i[CTRL_RUN_BIT]),
    .conn_i      (wdata_i[CTRL_CONN_BIT]),
    .mul_i       (wdata_i[MUL_W-1:0]),
    .pdiv_i      (wdata_i[CFG_PDIV_LSB +: PDIV_W]),
    .pend_run_o  (pend_run),
    .pend_conn_o (pend_conn),
    .pend_mul_o  (pend_mul),
    .pend_pdiv_o (pend_pdiv)
  );

  pll_commit_regs #(
    .MUL_W(MUL_W), .PDIV_W(PDIV_W), .MUL_DEF(MUL_DEF), .PDIV_DEF(PDIV_DEF)
  ) u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .lock_i      (lock_i),
    .pend_run_i  (pend_run),
    .pend_conn_i (pend_conn),
    .pend_mul_i  (pend_mul),
    .pend_pdiv_i (pend_pdiv),
    .run_o       (pll_run_o),
    .conn_o      (pll_conn_o),
    .mul_o       (pll_mul_o),
    .pdiv_o      (pll_pdiv_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == CTRL_ADDR) begin
        rdata_o[CTRL_RUN_BIT]  = pend_run;
        rdata_o[CTRL_CONN_BIT] = pend_conn;
      end else if (addr_i == CFG_ADDR) begin
        rdata_o[MUL_W-1:0]                = pend_mul;
        rdata_o[CFG_PDIV_LSB +: PDIV_W]   = pend_pdiv;
      end else if (addr_i == STAT_ADDR) begin
        rdata_o[MUL_W-1:0]                = pll_mul_o;
        rdata_o[CFG_PDIV_LSB +: PDIV_W]   = pll_pdiv_o;
        rdata_o[STAT_RUN_BIT]             = pll_run_o;
        rdata_o[STAT_CONN_BIT]            = pll_conn_o;
        rdata_o[STAT_LOCK_BIT]            = lock_i;
      end
    end
  end

  p_idle_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));
endmodule

// File: tb/pll_feed_guard_bench.sv
`timescale 1ns/1ps
module pll_feed_guard_bench;
  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic        lock;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h0C, 32'h0001_0010, 1'b0, 4'd1},  // R1 status at reset
    '{1'b1, 8'h04, 32'h0001_0010, 1'b0, 4'd1},  // R1 pending cfg
    '{1'b0, 8'h04, 32'h0003_0020, 1'b0, 4'd2},  // R2
    '{1'b0, 8'h00, 32'h0000_0001, 1'b0, 4'd2},
    '{1'b1, 8'h04, 32'h0003_0020, 1'b0, 4'd2},
    '{1'b1, 8'h00, 32'h0000_0001, 1'b0, 4'd2},
    '{1'b1, 8'h0C, 32'h0001_0010, 1'b0, 4'd2},
    '{1'b0, 8'h08, 32'h0000_0011, 1'b0, 4'd4},  // R4 wrong first key
    '{1'b0, 8'h08, 32'h0000_0055, 1'b0, 4'd4},
    '{1'b1, 8'h0C, 32'h0001_0010, 1'b0, 4'd4},
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b0, 4'd5},  // R5 wrong second key
    '{1'b0, 8'h08, 32'h0000_0056, 1'b0, 4'd5},
    '{1'b0, 8'h08, 32'h0000_0055, 1'b0, 4'd5},
    '{1'b1, 8'h0C, 32'h0001_0010, 1'b0, 4'd5},
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b0, 4'd6},  // R6 foreign read
    '{1'b1, 8'h00, 32'h0000_0001, 1'b0, 4'd6},
    '{1'b0, 8'h08, 32'h0000_0055, 1'b0, 4'd6},
    '{1'b1, 8'h0C, 32'h0001_0010, 1'b0, 4'd6},
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b0, 4'd6},  // R6 foreign write
    '{1'b0, 8'h14, 32'h0000_0000, 1'b0, 4'd6},
    '{1'b0, 8'h08, 32'h0000_0055, 1'b0, 4'd6},
    '{1'b1, 8'h0C, 32'h0001_0010, 1'b0, 4'd6},
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b0, 4'd6},  // R6 outside range
    '{1'b1, 8'h40, 32'h0000_0000, 1'b0, 4'd10}, // R10 unmapped
    '{1'b0, 8'h40, 32'h1234_5678, 1'b0, 4'd6},
    '{1'b0, 8'h08, 32'h0000_0055, 1'b0, 4'd3},  // R3 commit
    '{1'b1, 8'h0C, 32'h0103_0020, 1'b0, 4'd3},
    '{1'b0, 8'h04, 32'h0005_0030, 1'b0, 4'd7},  // R7 cfg frozen while running
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b0, 4'd7},
    '{1'b0, 8'h08, 32'h0000_0055, 1'b0, 4'd7},
    '{1'b1, 8'h0C, 32'h0103_0020, 1'b0, 4'd7},
    '{1'b1, 8'h04, 32'h0005_0030, 1'b0, 4'd2},
    '{1'b0, 8'h00, 32'h0000_0003, 1'b0, 4'd8},  // R8 no lock
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b0, 4'd8},
    '{1'b0, 8'h08, 32'h0000_0055, 1'b0, 4'd8},
    '{1'b1, 8'h0C, 32'h0103_0020, 1'b0, 4'd8},
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b1, 4'd8},  // R8 locked
    '{1'b0, 8'h08, 32'h0000_0055, 1'b1, 4'd8},
    '{1'b1, 8'h0C, 32'h0703_0020, 1'b1, 4'd8},
    '{1'b0, 8'h00, 32'h0000_0000, 1'b1, 4'd9},  // R9 stop clears connect
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b1, 4'd9},
    '{1'b0, 8'h08, 32'h0000_0055, 1'b1, 4'd9},
    '{1'b1, 8'h0C, 32'h0403_0020, 1'b1, 4'd9},
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b1, 4'd7},  // R7 cfg taken while stopped
    '{1'b0, 8'h08, 32'h0000_0055, 1'b1, 4'd7},
    '{1'b1, 8'h0C, 32'h0405_0030, 1'b1, 4'd7},
    '{1'b0, 8'h00, 32'h0000_0003, 1'b1, 4'd8},  // R8 run+connect from stopped
    '{1'b0, 8'h08, 32'h0000_00AA, 1'b1, 4'd8},
    '{1'b0, 8'h08, 32'h0000_0055, 1'b1, 4'd8},
    '{1'b1, 8'h0C, 32'h0505_0030, 1'b1, 4'd8}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        lock_i = 1'b0;
  logic        pll_run_o, pll_conn_o;
  logic [7:0]  pll_mul_o;
  logic [4:0]  pll_pdiv_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pll_feed_guard u_pll_feed_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .lock_i(lock_i),
    .pll_run_o(pll_run_o), .pll_conn_o(pll_conn_o),
    .pll_mul_o(pll_mul_o), .pll_pdiv_o(pll_pdiv_o)
  );

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic lk);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; lock_i = lk;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input logic lk, input int req);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1; lock_i = lk;
    #1 check(req, rdata_o, exp);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 read strobe low gives zero
    addr_i = 8'h0C;
    #1 check(10, rdata_o, 32'h0);
    // R1 outputs at reset
    check(1, {pll_run_o, pll_conn_o, pll_mul_o, pll_pdiv_o}, {1'b0, 1'b0, 8'h10, 5'h1});
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) bus_read(VECS[i].addr, VECS[i].data, VECS[i].lock, int'(VECS[i].req));
      else            bus_write(VECS[i].addr, VECS[i].data, VECS[i].lock);
    end
    // R8 ports agree with status
    check(8, {pll_run_o, pll_conn_o}, 2'b10);

    // R1 reset returns everything to defaults
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_read(8'h0C, 32'h0401_0010, 1'b1, 1);
    bus_read(8'h00, 32'h0000_0000, 1'b1, 1);

    // R3 exact latency: not visible one edge after the 0x55 write, visible after two
    bus_write(8'h00, 32'h1, 1'b0);
    bus_write(8'h08, 32'hAA, 1'b0);
    @(negedge clk_i);
    addr_i = 8'h08; wdata_i = 32'h55; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 8'h0C; rd_en_i = 1'b1;
    #1 check(3, rdata_o, 32'h0001_0010);
    @(negedge clk_i);
    #1 check(3, rdata_o, 32'h0101_0010);
    check(3, {31'b0, pll_run_o}, 32'h1);
    rd_en_i = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule